// File: doc/BRIEF.md
# Loadable Cascadable Synchronous Counter Stage

This block is one stage of a synchronous binary counter, four bits wide by default. On each rising clock edge it clears, loads a parallel word, advances by one, or holds. Clear takes priority over load, and load takes priority over counting. Both clear and load are synchronous: they take effect on a clock edge, not at the moment they are asserted. An active-low asynchronous reset only sets the power-on state.

Counting needs two enables, and they are not equivalent. Both must be high for the stage to advance. The terminal-count output is raised only when the stage holds its maximum value and the carry-side enable is high. The other enable has no effect on it. Because of this, several stages can be chained into a wide counter with no extra gates. Each stage's terminal count drives the carry enable of the next stage, and all stages share one clock and one common enable. A decade counter is obtained by decoding the outputs back into the synchronous clear.

Top module: `cnt_stage`

## Requirements
- R1: While rst_ni is low, q_o is 0 and tc_o is 0.
- R2: When clr_ni is low at a rising edge, q_o becomes 0 after that edge, whatever load_ni and the enables are. Before that edge, q_o is unchanged.
- R3: When clr_ni is high and load_ni is low at a rising edge, q_o takes data_i after that edge, whatever the enables are.
- R4: When clr_ni and load_ni are high and both en_p_i and en_t_i are high, q_o advances by one modulo 2^WIDTH at each edge. With the default width of 4, sixteen edges bring it back to its start value.
- R5: When clr_ni and load_ni are high and either enable is low, q_o holds its value.
- R6: tc_o is high exactly when en_t_i is high and q_o is all ones (1111 at the default width). en_p_i has no effect on tc_o.
- R7: Three stages with each tc_o wired to the next stage's en_t_i, and a shared en_p_i, count as one 12-bit counter through a full rollover. The chain has modulus 4096, and a low shared en_p_i freezes all three stages.
- R8: When clr_ni is driven low exactly when q_o[3] and q_o[0] are both 1, the stage repeats the sequence 0 to 9 and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| clr_ni | input | 1 | Synchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | WIDTH | Parallel load value |
| en_p_i | input | 1 | Count enable, shared across a chain |
| en_t_i | input | 1 | Count enable that also gates tc_o (carry in) |
| q_o | output | WIDTH | Count value |
| tc_o | output | 1 | Terminal count (carry out) |

## Verification
The clocked properties assume that the control inputs are settled at each rising edge and that they change only between edges. The bench drives every input one nanosecond after an edge and samples outputs away from the edges, so this assumption holds. The terminal-count property is combinational and needs en_t_i and q_o to be stable at the sampling point, which this timing also gives. The decade mode assumes the clear is decoded from the stage's own outputs in the same cycle, and the bench wires it that way.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_ni,
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output cnt_op_e op_o
);
  // clear > load > count
  always_comb begin
    if (!clr_ni)                op_o = OP_CLEAR;
    else if (!load_ni)          op_o = OP_LOAD;
    else if (en_p_i && en_t_i)  op_o = OP_COUNT;
    else                        op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH:0]   ones_below;
  logic [WIDTH-1:0] inc;

  assign ones_below[0] = 1'b1;
  // bit i toggles only when every lower bit is one
  for (genvar i = 0; i < WIDTH; i++) begin : g_tog
    assign inc[i]          = q_i[i] ^ ones_below[i];
    assign ones_below[i+1] = ones_below[i] & q_i[i];
  end

  always_comb begin
    unique case (op_i)
      OP_CLEAR: nxt_o = '0;
      OP_LOAD:  nxt_o = data_i;
      OP_COUNT: nxt_o = inc;
      default:  nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             en_t_i,
  output logic             tc_o
);
  assign tc_o = en_t_i & (&q_i);
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_p_i,
  input  logic             en_t_i,
  output logic [WIDTH-1:0] q_o,
  output logic             tc_o
);
  cnt_op_e          op;
  logic [WIDTH-1:0] q_q, q_d;

  cnt_ctrl u_ctrl (
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .en_p_i (en_p_i),
    .en_t_i (en_t_i),
    .op_o   (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op_i  (op),
    .q_i   (q_q),
    .data_i(data_i),
    .nxt_o (q_d)
  );

  cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q_i   (q_q),
    .en_t_i(en_t_i),
    .tc_o  (tc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cnt_stage_chk.sv
module cnt_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             en_p_i,
  input logic             en_t_i,
  input logic [WIDTH-1:0] q_o,
  input logic             tc_o
);
  // R1
  always_comb if (!rst_ni) rst_state_chk: assert (q_o == '0);

  // R2
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> q_o == '0);

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !load_ni |=> q_o == $past(data_i));

  // R4
  count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && en_p_i && en_t_i |=> q_o == WIDTH'($past(q_o) + 1'b1));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !(en_p_i && en_t_i) |=> $stable(q_o));

  // R6
  tc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_t_i |-> !tc_o);

  // R6
  tc_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> q_o == '1);
endmodule

bind cnt_stage cnt_stage_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cnt_stage_test.sv
module cnt_stage_test;
  localparam int W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // single stage under test
  logic         clr_ni = 1, load_ni = 1, en_p = 0, en_t = 0;
  logic [W-1:0] data = '0, q;
  logic         tc;

  cnt_stage #(.WIDTH(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .load_ni(load_ni),
    .data_i(data), .en_p_i(en_p), .en_t_i(en_t), .q_o(q), .tc_o(tc)
  );

  // three-stage chain
  logic         ch_p = 0, ch_t = 0;
  logic [W-1:0] cq0, cq1, cq2;
  logic         ct0, ct1, ct2;
  logic         one = 1'b1;
  logic [W-1:0] zero = '0;

  cnt_stage #(.WIDTH(W)) u_s0 (.clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(one), .load_ni(one),
    .data_i(zero), .en_p_i(ch_p), .en_t_i(ch_t), .q_o(cq0), .tc_o(ct0));
  cnt_stage #(.WIDTH(W)) u_s1 (.clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(one), .load_ni(one),
    .data_i(zero), .en_p_i(ch_p), .en_t_i(ct0), .q_o(cq1), .tc_o(ct1));
  cnt_stage #(.WIDTH(W)) u_s2 (.clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(one), .load_ni(one),
    .data_i(zero), .en_p_i(ch_p), .en_t_i(ct1), .q_o(cq2), .tc_o(ct2));

  // decade stage: clear decoded from bits 3 and 0
  logic [W-1:0] bq;
  logic         bt, b_en = 0, b_clr;
  assign b_clr = ~(bq[3] & bq[0]);

  cnt_stage #(.WIDTH(W)) u_bcd (.clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(b_clr), .load_ni(one),
    .data_i(zero), .en_p_i(b_en), .en_t_i(b_en), .q_o(bq), .tc_o(bt));

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int exp;
    en_t = 1;
    #20;
    // R1 reset state
    chk(q == 0, "R1 q", q, 0);
    chk(tc == 0, "R1 tc", tc, 0);
    @(negedge clk_i);
    rst_ni = 1;
    tick();

    // R4 full sweep, modulus 16, and R6 tc decode
    en_p = 1; en_t = 1;
    exp = 0;
    for (int i = 0; i < 17; i++) begin
      chk(q == exp, "R4 count", q, exp);
      chk(tc == (exp == 15), "R6 tc", tc, exp == 15);
      tick();
      exp = (exp + 1) % 16;
    end

    // R5 hold with each enable low
    en_p = 0;
    exp = q;
    tick(); tick();
    chk(q == exp, "R5 hold p low", q, exp);
    en_p = 1; en_t = 0;
    tick(); tick();
    chk(q == exp, "R5 hold t low", q, exp);

    // R3 load, enables off, and with enables on
    data = 4'd15; load_ni = 0; en_t = 0; en_p = 0;
    tick();
    chk(q == 15, "R3 load", q, 15);
    // R6 tc needs en_t, en_p irrelevant
    load_ni = 1;
    #1 chk(tc == 0, "R6 tc en_t low", tc, 0);
    en_t = 1; en_p = 0;
    #1 chk(tc == 1, "R6 tc en_p low", tc, 1);
    en_p = 1;
    #1 chk(tc == 1, "R6 tc en_p high", tc, 1);
    data = 4'd6; load_ni = 0;
    tick();
    chk(q == 6, "R3 load over count", q, 6);

    // R2 clear beats load, waits for edge
    data = 4'd9; clr_ni = 0;
    #2 chk(q == 6, "R2 not immediate", q, 6);
    tick();
    chk(q == 0, "R2 clear", q, 0);
    clr_ni = 1; load_ni = 1;
    tick();
    chk(q == 1, "R4 after clear", q, 1);
    en_p = 0;

    // R7 chain through full rollover
    ch_p = 1; ch_t = 1;
    exp = 0;
    for (int i = 0; i < 4200; i++) begin
      chk({cq2, cq1, cq0} == 12'(exp), "R7 chain", {cq2, cq1, cq0}, exp);
      tick();
      exp = (exp + 1) % 4096;
    end
    // shared enable low freezes the chain
    ch_p = 0;
    tick(); tick(); tick();
    chk({cq2, cq1, cq0} == 12'(exp), "R7 freeze", {cq2, cq1, cq0}, exp);
    ch_p = 1;
    tick();
    exp = (exp + 1) % 4096;
    chk({cq2, cq1, cq0} == 12'(exp), "R7 resume", {cq2, cq1, cq0}, exp);
    ch_p = 0;

    // R8 decade sequence
    b_en = 1;
    exp = 0;
    for (int i = 0; i < 35; i++) begin
      chk(bq == 4'(exp), "R8 decade", bq, exp);
      tick();
      exp = (exp + 1) % 10;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule